// File: doc/BRIEF.md
# Key-Sequence Register Unlock Controller

This block guards a flash control register so that a stray bus write cannot start a program or erase. After reset the control register is write-locked. Software opens it by writing two fixed magic words, in order, to a dedicated key register. A second key register, with the same two words, opens a second level: a write-enable bit that alone allows the option-byte program and option-byte erase bits to be changed. A wrong key write locks everything again and returns a bus error.

The block sits on a simple register bus that carries a write strobe, a read strobe, a byte address and write data. Reads of the control register return its fields. Reads of either key register return zero. The lock state and the option write-enable state are also driven out as status pins. The flash operations that the control bits start are outside this block.

Top module: `ksu_unlock_ctrl`

## Requirements
- R1: After reset, `lock_o` is 1, `opt_wen_o` is 0 and the control register (offset 0x00) reads 0x0000_0001. Control layout: bit 0 lock, bit 1 option write-enable, bit 2 option program, bit 3 option erase, bit 4 reload, bits [15:8] general control.
- R2: While locked, a control write updates only the reload bit (bit 4). All other bits keep their values.
- R3: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) clears the lock bit at the edge that samples the second write.
- R4: Writing 1 to bit 0 of an unlocked control register sets the lock bit and clears the option write-enable bit in the same cycle.
- R5: A key-register write that does not carry the expected word sets the lock bit and clears option write-enable. Examples are the second word written first, and the first word written twice. `bus_err` is then high for the one cycle after that write.
- R6: A write to any other address between the two key words cancels the sequence and gives no error. A following second word alone counts as a wrong key.
- R7: The same two words written to the option key register (offset 0x08) set option write-enable (bit 1), but only while unlocked. While locked, option key writes are ignored, change no state and raise no error.
- R8: Option program (bit 2) and option erase (bit 3) take the written value only while option write-enable is 1 and the register is unlocked.
- R9: Writing 0 to bit 1 clears option write-enable and protects bits 2 and 3 again. Writing 1 to bit 1 never sets it.
- R10: A wrong option key write while unlocked raises `bus_err` for one cycle and clears option write-enable. The lock bit stays 0.
- R11: Both key registers read as zero, and writes to the control register or to unmapped addresses never raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle rd_en is high |
| bus_err | output | 1 | Error response, high for one cycle after a wrong key write |
| lock_o | output | 1 | Control register lock state |
| opt_wen_o | output | 1 | Option-byte write-enable state |

## Verification
On every cycle, the assertions check the following. Unlocking only ever follows a second-word write to the key register. Option write-enable never coexists with the lock. Locked control writes leave the general bits unchanged, and the option bits never move while their enable is clear. Every out-of-range key word produces the error and the relock. The order-dependent cases can only be shown by the bench scenarios, because they depend on the history of earlier writes. These cases are: a doubled first word, an interleaved write that cancels the sequence, option keys that are ignored while locked, and the exact field values read back after each step.

// File: rtl/ksu_pkg.sv
package ksu_pkg;
   localparam int LOCK_BIT   = 0;
   localparam int OWEN_BIT   = 1;
   localparam int OPROG_BIT  = 2;
   localparam int OERASE_BIT = 3;
   localparam int RELOAD_BIT = 4;
   localparam int GEN_LSB    = 8;

   typedef enum logic {
      KS_IDLE  = 1'b0,
      KS_ARMED = 1'b1
   } key_state_e;

   localparam int NUM_SEQ  = 2;
   localparam int SEQ_MAIN = 0;
   localparam int SEQ_OPT  = 1;
endpackage

// File: rtl/ksu_addr_decode.sv
module ksu_addr_decode #(
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFS = 0,
   parameter int KEY_OFS  = 4,
   parameter int OKEY_OFS = 8
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_ctrl,
   output logic              wr_key,
   output logic              wr_okey,
   output logic              rd_ctrl
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);
   localparam logic [ADDR_W-1:0] A_OKEY = ADDR_W'(OKEY_OFS);

   always_comb begin
      wr_ctrl = wr_en && (addr == A_CTRL);
      wr_key  = wr_en && (addr == A_KEY);
      wr_okey = wr_en && (addr == A_OKEY);
      rd_ctrl = rd_en && (addr == A_CTRL);
   end
endmodule

// File: rtl/ksu_key_seq.sv
module ksu_key_seq
   import ksu_pkg::*;
#(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A = DATA_W'(32'h4567_0123),
   parameter logic [DATA_W-1:0] KEY_B = DATA_W'(32'hCDEF_89AB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              key_wr,
   input  logic              other_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              seq_ok,
   output logic              seq_bad,
   output logic              armed
);
   key_state_e st_q, st_d;

   always_comb begin
      st_d    = st_q;
      seq_ok  = 1'b0;
      seq_bad = 1'b0;
      if (clr) begin
         st_d = KS_IDLE;
      end else if (key_wr && en) begin
         if (st_q == KS_IDLE) begin
            if (wdata == KEY_A) st_d = KS_ARMED;
            else                seq_bad = 1'b1;
         end else begin
            st_d = KS_IDLE;
            if (wdata == KEY_B) seq_ok  = 1'b1;
            else                seq_bad = 1'b1;
         end
      end else if (other_wr) begin
         st_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

   assign armed = (st_q == KS_ARMED);
endmodule

// File: rtl/ksu_ctrl_reg.sv
module ksu_ctrl_reg
   import ksu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int GEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              main_ok,
   input  logic              main_bad,
   input  logic              opt_ok,
   input  logic              opt_bad,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              lock,
   output logic              owen
);
   logic             lock_q, owen_q, oprog_q, oerase_q, reload_q;
   logic [GEN_W-1:0] gen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= 1'b1;
         owen_q   <= 1'b0;
         oprog_q  <= 1'b0;
         oerase_q <= 1'b0;
         reload_q <= 1'b0;
         gen_q    <= '0;
      end else if (main_bad) begin
         lock_q <= 1'b1;
         owen_q <= 1'b0;
      end else if (main_ok) begin
         lock_q <= 1'b0;
      end else if (opt_ok) begin
         owen_q <= 1'b1;
      end else if (opt_bad) begin
         owen_q <= 1'b0;
      end else if (wr) begin
         reload_q <= wdata[RELOAD_BIT];
         if (!lock_q) begin
            gen_q <= wdata[GEN_LSB +: GEN_W];
            if (owen_q) begin
               oprog_q  <= wdata[OPROG_BIT];
               oerase_q <= wdata[OERASE_BIT];
            end
            if (wdata[LOCK_BIT]) begin
               lock_q <= 1'b1;
               owen_q <= 1'b0;
            end else if (!wdata[OWEN_BIT]) begin
               owen_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      ctrl_q                      = '0;
      ctrl_q[LOCK_BIT]            = lock_q;
      ctrl_q[OWEN_BIT]            = owen_q;
      ctrl_q[OPROG_BIT]           = oprog_q;
      ctrl_q[OERASE_BIT]          = oerase_q;
      ctrl_q[RELOAD_BIT]          = reload_q;
      ctrl_q[GEN_LSB +: GEN_W]    = gen_q;
   end

   assign lock = lock_q;
   assign owen = owen_q;
endmodule

// File: rtl/ksu_unlock_ctrl.sv
module ksu_unlock_ctrl
   import ksu_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 32,
   parameter int              GEN_W    = 8,
   parameter int              CTRL_OFS = 0,
   parameter int              KEY_OFS  = 4,
   parameter int              OKEY_OFS = 8,
   parameter logic [DATA_W-1:0] KEY_A  = DATA_W'(32'h4567_0123),
   parameter logic [DATA_W-1:0] KEY_B  = DATA_W'(32'hCDEF_89AB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_err,
   output logic              lock_o,
   output logic              opt_wen_o
);
   localparam int MAX_OFS = 1 << ADDR_W;

   if (DATA_W < GEN_LSB + GEN_W) begin : g_bad_width
      $error("DATA_W too narrow for the control layout");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("the two key words must differ");
   end
   if (CTRL_OFS == KEY_OFS || CTRL_OFS == OKEY_OFS || KEY_OFS == OKEY_OFS) begin : g_bad_ofs
      $error("register offsets must be distinct");
   end
   if (CTRL_OFS >= MAX_OFS || KEY_OFS >= MAX_OFS || OKEY_OFS >= MAX_OFS) begin : g_bad_range
      $error("register offset outside the address range");
   end

   logic              wr_ctrl, wr_key, wr_okey, rd_ctrl;
   logic [DATA_W-1:0] ctrl_q;
   logic              lock, owen;
   logic              err_q;

   logic [NUM_SEQ-1:0] s_en, s_clr, s_wr, s_other, s_ok, s_bad, s_armed;

   ksu_addr_decode #(
      .ADDR_W  (ADDR_W),
      .CTRL_OFS(CTRL_OFS),
      .KEY_OFS (KEY_OFS),
      .OKEY_OFS(OKEY_OFS)
   ) dec_i (
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wr_ctrl(wr_ctrl),
      .wr_key (wr_key),
      .wr_okey(wr_okey),
      .rd_ctrl(rd_ctrl)
   );

   assign s_wr[SEQ_MAIN]  = wr_key;
   assign s_en[SEQ_MAIN]  = 1'b1;
   assign s_clr[SEQ_MAIN] = 1'b0;
   assign s_wr[SEQ_OPT]   = wr_okey;
   assign s_en[SEQ_OPT]   = !lock;
   assign s_clr[SEQ_OPT]  = lock;

   for (genvar gi = 0; gi < NUM_SEQ; gi++) begin : g_seq
      assign s_other[gi] = wr_en && !s_wr[gi];
      ksu_key_seq #(
         .DATA_W(DATA_W),
         .KEY_A (KEY_A),
         .KEY_B (KEY_B)
      ) seq_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (s_en[gi]),
         .clr     (s_clr[gi]),
         .key_wr  (s_wr[gi]),
         .other_wr(s_other[gi]),
         .wdata   (wdata),
         .seq_ok  (s_ok[gi]),
         .seq_bad (s_bad[gi]),
         .armed   (s_armed[gi])
      );
   end

   ksu_ctrl_reg #(
      .DATA_W(DATA_W),
      .GEN_W (GEN_W)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctrl),
      .wdata   (wdata),
      .main_ok (s_ok[SEQ_MAIN]),
      .main_bad(s_bad[SEQ_MAIN]),
      .opt_ok  (s_ok[SEQ_OPT]),
      .opt_bad (s_bad[SEQ_OPT]),
      .ctrl_q  (ctrl_q),
      .lock    (lock),
      .owen    (owen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= |s_bad;
   end

   always_comb begin
      rdata = '0;
      if (rd_ctrl) rdata = ctrl_q;
   end

   assign bus_err   = err_q;
   assign lock_o    = lock;
   assign opt_wen_o = owen;
endmodule

// File: rtl/ksu_unlock_chk.sv
module ksu_unlock_chk
   import ksu_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 32,
   parameter int              GEN_W    = 8,
   parameter int              CTRL_OFS = 0,
   parameter int              KEY_OFS  = 4,
   parameter int              OKEY_OFS = 8,
   parameter logic [DATA_W-1:0] KEY_A  = DATA_W'(32'h4567_0123),
   parameter logic [DATA_W-1:0] KEY_B  = DATA_W'(32'hCDEF_89AB)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              bus_err,
   input logic              lock_o,
   input logic              opt_wen_o,
   input logic [DATA_W-1:0] ctrl_q
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);
   localparam logic [ADDR_W-1:0] A_OKEY = ADDR_W'(OKEY_OFS);

   // R3
   unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> $past(wr_en && addr == A_KEY && wdata == KEY_B));

   // R2
   locked_gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL && lock_o) |=>
         ctrl_q[GEN_LSB +: GEN_W] == $past(ctrl_q[GEN_LSB +: GEN_W]));

   // R4
   owen_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_wen_o |-> !lock_o);

   // R5
   bad_key_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_KEY && wdata != KEY_A && wdata != KEY_B) |=>
         (bus_err && lock_o && !opt_wen_o));

   // R7
   owen_set_by_okey_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(opt_wen_o) |-> $past(wr_en && addr == A_OKEY && wdata == KEY_B && !lock_o));

   // R8
   opt_bits_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_wen_o |=> ctrl_q[OERASE_BIT:OPROG_BIT] == $past(ctrl_q[OERASE_BIT:OPROG_BIT]));

   // R11
   key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == A_KEY || addr == A_OKEY)) |-> rdata == '0);

   // R11
   err_only_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(wr_en && (addr == A_KEY || addr == A_OKEY)));
endmodule

bind ksu_unlock_ctrl ksu_unlock_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .GEN_W   (GEN_W),
   .CTRL_OFS(CTRL_OFS),
   .KEY_OFS (KEY_OFS),
   .OKEY_OFS(OKEY_OFS),
   .KEY_A   (KEY_A),
   .KEY_B   (KEY_B)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .bus_err  (bus_err),
   .lock_o   (lock_o),
   .opt_wen_o(opt_wen_o),
   .ctrl_q   (ctrl_q)
);

// File: tb/ksu_unlock_ctrl_tb_top.sv
module ksu_unlock_ctrl_tb_top;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam logic [7:0]  A_CTRL = 8'h00;
   localparam logic [7:0]  A_KEY  = 8'h04;
   localparam logic [7:0]  A_OKEY = 8'h08;
   localparam logic [31:0] K1 = 32'h4567_0123;
   localparam logic [31:0] K2 = 32'hCDEF_89AB;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              bus_err, lock_o, opt_wen_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;
   logic last_err;

   always #10 clk = ~clk;

   ksu_unlock_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .bus_err(bus_err), .lock_o(lock_o),
      .opt_wen_o(opt_wen_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // write is sampled at the posedge; bus_err is captured at the next negedge
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      last_err = bus_err;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #2 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic chk_ctrl(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      bus_rd(A_CTRL, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 lock_o", 32'(lock_o), 32'd1);
      chk("R1 opt_wen_o", 32'(opt_wen_o), 32'd0);
      chk_ctrl("R1 ctrl reset value", 32'h0000_0001);
      bus_rd(A_KEY, v);  chk("R11 key reads zero", v, 32'h0);
      bus_rd(A_OKEY, v); chk("R11 okey reads zero", v, 32'h0);
   endtask

   task automatic t_locked();
      bus_wr(A_CTRL, 32'h0000_FF1E);
      chk("R11 no err on ctrl write", 32'(last_err), 32'd0);
      chk_ctrl("R2 locked write only reload", 32'h0000_0011);
      bus_wr(A_CTRL, 32'h0000_0000);
      chk_ctrl("R2 reload cleared while locked", 32'h0000_0001);
      bus_wr(A_OKEY, K1);
      chk("R7 okey ignored while locked no err", 32'(last_err), 32'd0);
      bus_wr(A_OKEY, K2);
      chk("R7 okey ignored while locked owen", 32'(opt_wen_o), 32'd0);
      chk("R7 okey ignored while locked lock", 32'(lock_o), 32'd1);
      bus_wr(8'h40, 32'h1234_5678);
      chk("R11 no err on unmapped write", 32'(last_err), 32'd0);
   endtask

   task automatic t_unlock();
      bus_wr(A_KEY, K1);
      chk("R3 first key no err", 32'(last_err), 32'd0);
      chk("R3 still locked after first key", 32'(lock_o), 32'd1);
      bus_wr(A_KEY, K2);
      chk("R3 second key no err", 32'(last_err), 32'd0);
      chk("R3 unlocked", 32'(lock_o), 32'd0);
      chk_ctrl("R3 ctrl after unlock", 32'h0000_0000);
   endtask

   task automatic t_opt();
      bus_wr(A_CTRL, 32'h0000_AB0C);
      chk_ctrl("R8 opt bits blocked, gen written", 32'h0000_AB00);
      bus_wr(A_CTRL, 32'h0000_0002);
      chk_ctrl("R9 writing 1 to owen does not set", 32'h0000_0000);
      bus_wr(A_OKEY, K1);
      bus_wr(A_OKEY, K2);
      chk("R7 owen set", 32'(opt_wen_o), 32'd1);
      chk_ctrl("R7 ctrl shows owen", 32'h0000_0002);
      bus_wr(A_CTRL, 32'h0000_000E);
      chk_ctrl("R8 opt bits written", 32'h0000_000E);
      bus_wr(A_CTRL, 32'h0000_0000);
      chk_ctrl("R9 owen cleared", 32'h0000_0000);
      bus_wr(A_CTRL, 32'h0000_000C);
      chk_ctrl("R9 opt bits protected again", 32'h0000_0000);
   endtask

   task automatic t_opt_bad();
      bus_wr(A_OKEY, K1);
      bus_wr(A_OKEY, K2);
      chk("R10 owen set before wrong key", 32'(opt_wen_o), 32'd1);
      bus_wr(A_OKEY, 32'h0000_1234);
      chk("R10 err on wrong okey", 32'(last_err), 32'd1);
      chk("R10 owen cleared", 32'(opt_wen_o), 32'd0);
      chk("R10 lock unchanged", 32'(lock_o), 32'd0);
      @(negedge clk);
      chk("R10 err lasts one cycle", 32'(bus_err), 32'd0);
   endtask

   task automatic t_relock();
      bus_wr(A_OKEY, K1);
      bus_wr(A_OKEY, K2);
      bus_wr(A_CTRL, 32'h0000_5502);
      chk_ctrl("R4 gen written unlocked", 32'h0000_5502);
      bus_wr(A_CTRL, 32'h0000_5503);
      chk("R4 relocked", 32'(lock_o), 32'd1);
      chk("R4 owen cleared on relock", 32'(opt_wen_o), 32'd0);
      chk_ctrl("R4 ctrl after relock", 32'h0000_5501);
      bus_wr(A_CTRL, 32'h0000_0000);
      chk_ctrl("R2 gen held while locked", 32'h0000_5501);
   endtask

   task automatic t_wrong_key();
      bus_wr(A_KEY, K2);
      chk("R5 second word first gives err", 32'(last_err), 32'd1);
      chk("R5 still locked", 32'(lock_o), 32'd1);
      bus_wr(A_KEY, K1);
      chk("R5 first word no err", 32'(last_err), 32'd0);
      bus_wr(A_KEY, K1);
      chk("R5 doubled first word err", 32'(last_err), 32'd1);
      chk("R5 locked after doubled word", 32'(lock_o), 32'd1);
      bus_wr(A_KEY, K1);
      bus_wr(A_KEY, K2);
      bus_wr(A_OKEY, K1);
      bus_wr(A_OKEY, K2);
      chk("R5 setup owen", 32'(opt_wen_o), 32'd1);
      bus_wr(A_KEY, 32'hDEAD_BEEF);
      chk("R5 wrong key err while unlocked", 32'(last_err), 32'd1);
      chk("R5 wrong key relocks", 32'(lock_o), 32'd1);
      chk("R5 wrong key clears owen", 32'(opt_wen_o), 32'd0);
   endtask

   task automatic t_cancel();
      bus_wr(A_KEY, K1);
      bus_wr(A_CTRL, 32'h0000_0000);
      chk("R6 interleaved write no err", 32'(last_err), 32'd0);
      bus_wr(A_KEY, K2);
      chk("R6 second word after cancel err", 32'(last_err), 32'd1);
      chk("R6 still locked", 32'(lock_o), 32'd1);
      bus_wr(A_KEY, K1);
      bus_wr(A_KEY, K2);
      chk("R6 clean sequence unlocks", 32'(lock_o), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_unlock();
      t_opt();
      t_opt_bad();
      t_relock();
      t_wrong_key();
      t_cancel();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule